// File: doc/BRIEF.md
# Windowed coherent ADC averager

This block sits in the ADC clock domain and builds a low-noise picture of a repeating reflected waveform. A pulse period is cut into consecutive windows of 65 samples. Each window is first summed over time, and that sum is then added into a per-window accumulator. The same window position is accumulated again in every repeated period, so the accumulators grow coherently with the signal while uncorrelated noise averages out.

A run begins with a `start` pulse. The pulse captures the period length, the repetition count and the sample interpretation, and then zeroes every accumulator. Each period begins on a `trig` pulse. Once the requested number of periods has been folded in, the accumulators are sent out as a byte stream with a valid/ready handshake. Framing into network packets and the final division into means are left to downstream logic.

Top module: `coh_window_avg`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` and `out_last` are low.
- R2: With `signed_mode` captured as 0, each bin holds the sum of the raw unsigned 12-bit codes of its 65 samples, added over all repetitions.
- R3: With `signed_mode` captured as 1, each sample is treated as offset binary. Its MSB is inverted and the result is sign-extended, so code 0x800 counts as 0 and code 0x000 counts as -2048. Bins are 32-bit two's complement.
- R4: In unsigned mode, a sample with `smp_ovr` high counts as 4095. In signed mode, `smp_ovr` has no effect.
- R5: A period starts on the first cycle `trig` is high while the block waits for a period, and that cycle's sample is sample 0. Samples taken while no period is armed are ignored, and so is a `trig` that arrives inside a period.
- R6: The number of bins is `period_len`/65. The stream carries exactly four bytes per bin, and `out_last` is high only on the final byte.
- R7: Bins are streamed in ascending window order, each least-significant byte first, and the stream has no gaps until its last byte is accepted.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values. A byte is consumed only on a cycle where both are high.
- R9: Every `start` clears all bins, so no result carries into the next run.
- R10: A `start` pulse that arrives while a run is in progress is ignored, and the configuration in use stays unchanged.
- R11: After the final byte is accepted, `out_valid` goes low in the next cycle and the block waits for a new `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | ADC sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the configuration and begin a new run (ignored unless idle) |
| signed_mode | input | 1 | Sample interpretation, captured on start: 0 unsigned, 1 offset-binary signed |
| period_len | input | PERIOD_W (16) | Period length in samples, a multiple of 65, captured on start |
| rep_total | input | REP_W (13) | Number of periods to accumulate (1 to 4096), captured on start |
| trig | input | 1 | Period start marker |
| smp | input | SAMPLE_W (12) | ADC sample, one per clock |
| smp_ovr | input | 1 | ADC out-of-range flag for `smp` |
| out_data | output | 8 | Result byte |
| out_valid | output | 1 | `out_data` is valid |
| out_ready | input | 1 | Consumer accepts the byte |
| out_last | output | 1 | Final byte of the result stream |

## Verification
The properties assume that `out_ready` may change freely in any cycle, and that reset is applied once before the first run. The data path assumes `period_len` is a nonzero multiple of 65 that fits in MAX_BINS windows and that `rep_total` is at least 1. Outside those limits, bin counts and accumulations are undefined, so the stimulus keeps every configuration inside them. Junk samples, stray triggers, a misplaced `start` and a reset in mid-period are placed only where the requirements define the outcome. The handshake is throttled in a repeating pattern so that the hold rules are exercised.

// File: rtl/coh_avg_pkg.sv
package coh_avg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ARM,
        ST_RUN,
        ST_DRAIN,
        ST_STREAM
    } avg_state_t;

    localparam int unsigned BYTES_PER_BIN = 4;

endpackage

// File: rtl/coh_avg_cond.sv
// Sample conditioning: maps a raw ADC code to a signed value one bit wider.
module coh_avg_cond #(
    parameter int unsigned SAMPLE_W = 12
) (
    input  logic [SAMPLE_W-1:0] smp,
    input  logic                ovr,
    input  logic                signed_mode,
    output logic [SAMPLE_W:0]   val
);
    localparam int unsigned MSB = SAMPLE_W - 1;

    always_comb begin
        if (signed_mode) begin
            // offset binary to two's complement, then one bit of sign extension
            val = {~smp[MSB], ~smp[MSB], smp[MSB-1:0]};
        end else if (ovr) begin
            val = {1'b0, {SAMPLE_W{1'b1}}};
        end else begin
            val = {1'b0, smp};
        end
    end

endmodule

// File: rtl/coh_avg_window.sv
// Time-domain window summation; emits one sum per WIN_LEN accepted samples.
module coh_avg_window #(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned WIN_LEN  = 65,
    parameter int unsigned BIN_W    = 4,
    localparam int unsigned CNT_W   = $clog2(WIN_LEN),
    localparam int unsigned WSUM_W  = SAMPLE_W + 1 + CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic [SAMPLE_W:0]   val,
    input  logic [BIN_W-1:0]    bin_i,
    output logic                win_end,
    output logic                wr_vld,
    output logic [BIN_W-1:0]    wr_bin,
    output logic [WSUM_W-1:0]   wr_sum
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WSUM_W-1:0] run;
        logic [WSUM_W-1:0] sum;
        logic [BIN_W-1:0]  bin;
        logic              vld;
    } win_t;

    win_t w_d, w_q;
    logic [WSUM_W-1:0] val_ext;
    logic [WSUM_W-1:0] run_nx;

    assign val_ext = {{(WSUM_W-SAMPLE_W-1){val[SAMPLE_W]}}, val};
    assign run_nx  = w_q.run + val_ext;
    assign win_end = en && (w_q.cnt == CNT_W'(WIN_LEN - 1));

    always_comb begin
        w_d     = w_q;
        w_d.vld = 1'b0;
        if (clr) begin
            w_d.cnt = '0;
            w_d.run = '0;
        end else if (en) begin
            if (win_end) begin
                w_d.cnt = '0;
                w_d.run = '0;
                w_d.sum = run_nx;
                w_d.bin = bin_i;
                w_d.vld = 1'b1;
            end else begin
                w_d.cnt = w_q.cnt + 1'b1;
                w_d.run = run_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign wr_vld = w_q.vld;
    assign wr_bin = w_q.bin;
    assign wr_sum = w_q.sum;

endmodule

// File: rtl/coh_avg_bins.sv
// Bin accumulator storage: clear port, read-modify-write port, async read port.
module coh_avg_bins #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned ACC_W  = 32,
    parameter int unsigned WSUM_W = 20,
    localparam int unsigned BIN_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              clr_we,
    input  logic [BIN_W-1:0]  clr_addr,
    input  logic              acc_we,
    input  logic [BIN_W-1:0]  acc_addr,
    input  logic [WSUM_W-1:0] acc_val,
    input  logic [BIN_W-1:0]  rd_addr,
    output logic [ACC_W-1:0]  rd_data
);
    logic [ACC_W-1:0] mem [DEPTH];
    logic [ACC_W-1:0] addend;

    assign addend  = {{(ACC_W-WSUM_W){acc_val[WSUM_W-1]}}, acc_val};
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (clr_we) begin
            mem[clr_addr] <= '0;
        end else if (acc_we) begin
            mem[acc_addr] <= mem[acc_addr] + addend;
        end
    end

endmodule

// File: rtl/coh_window_avg.sv
module coh_window_avg
    import coh_avg_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned WIN_LEN  = 65,
    parameter int unsigned ACC_W    = 32,
    parameter int unsigned MAX_BINS = 16,
    parameter int unsigned PERIOD_W = 16,
    parameter int unsigned REP_W    = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                signed_mode,
    input  logic [PERIOD_W-1:0] period_len,
    input  logic [REP_W-1:0]    rep_total,
    input  logic                trig,
    input  logic [SAMPLE_W-1:0] smp,
    input  logic                smp_ovr,
    output logic [7:0]          out_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                out_last
);
    localparam int unsigned BIN_W  = $clog2(MAX_BINS);
    localparam int unsigned NB_W   = BIN_W + 1;
    localparam int unsigned CNT_W  = $clog2(WIN_LEN);
    localparam int unsigned WSUM_W = SAMPLE_W + 1 + CNT_W;
    localparam int unsigned LANE_W = $clog2(BYTES_PER_BIN);

    typedef struct packed {
        avg_state_t          st;
        logic [PERIOD_W-1:0] plen;
        logic [REP_W-1:0]    reps;
        logic                smode;
        logic [PERIOD_W-1:0] pcnt;
        logic [BIN_W-1:0]    bin;
        logic [REP_W-1:0]    rep;
        logic [NB_W-1:0]     nbins;
        logic [BIN_W-1:0]    clr;
        logic [BIN_W-1:0]    sbin;
        logic [LANE_W-1:0]   lane;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                samp_en;
    logic                clr_we;
    logic                win_clr;
    logic                win_end;
    logic                wr_vld;
    logic [BIN_W-1:0]    wr_bin;
    logic [WSUM_W-1:0]   wr_sum;
    logic [SAMPLE_W:0]   cond_val;
    logic [ACC_W-1:0]    rd_word;
    logic                final_byte;

    coh_avg_cond #(.SAMPLE_W(SAMPLE_W)) u_cond (
        .smp         (smp),
        .ovr         (smp_ovr),
        .signed_mode (c_q.smode),
        .val         (cond_val)
    );

    coh_avg_window #(
        .SAMPLE_W (SAMPLE_W),
        .WIN_LEN  (WIN_LEN),
        .BIN_W    (BIN_W)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (win_clr),
        .en      (samp_en),
        .val     (cond_val),
        .bin_i   (c_q.bin),
        .win_end (win_end),
        .wr_vld  (wr_vld),
        .wr_bin  (wr_bin),
        .wr_sum  (wr_sum)
    );

    coh_avg_bins #(
        .DEPTH  (MAX_BINS),
        .ACC_W  (ACC_W),
        .WSUM_W (WSUM_W)
    ) u_bins (
        .clk      (clk),
        .clr_we   (clr_we),
        .clr_addr (c_q.clr),
        .acc_we   (wr_vld),
        .acc_addr (wr_bin),
        .acc_val  (wr_sum),
        .rd_addr  (c_q.sbin),
        .rd_data  (rd_word)
    );

    assign final_byte = (c_q.lane == LANE_W'(BYTES_PER_BIN - 1))
                     && ({1'b0, c_q.sbin} == c_q.nbins - 1'b1);

    always_comb begin
        c_d       = c_q;
        samp_en   = 1'b0;
        clr_we    = 1'b0;
        win_clr   = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        out_data  = rd_word[c_q.lane*8 +: 8];
        case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    c_d.st    = ST_CLEAR;
                    c_d.plen  = period_len;
                    c_d.reps  = rep_total;
                    c_d.smode = signed_mode;
                    c_d.clr   = '0;
                    win_clr   = 1'b1;
                end
            end
            ST_CLEAR: begin
                clr_we  = 1'b1;
                c_d.clr = c_q.clr + 1'b1;
                if (c_q.clr == BIN_W'(MAX_BINS - 1)) begin
                    c_d.st   = ST_ARM;
                    c_d.rep  = '0;
                    c_d.bin  = '0;
                    c_d.pcnt = '0;
                end
            end
            ST_ARM: begin
                if (trig) begin
                    samp_en  = 1'b1;
                    c_d.pcnt = PERIOD_W'(1);
                    c_d.st   = ST_RUN;
                end
            end
            ST_RUN: begin
                samp_en  = 1'b1;
                c_d.pcnt = c_q.pcnt + 1'b1;
                if (win_end) begin
                    c_d.bin = c_q.bin + 1'b1;
                end
                if (c_q.pcnt == c_q.plen - 1'b1) begin
                    c_d.nbins = {1'b0, c_q.bin} + 1'b1;
                    c_d.bin   = '0;
                    c_d.pcnt  = '0;
                    if (c_q.rep == c_q.reps - 1'b1) begin
                        c_d.st = ST_DRAIN;
                    end else begin
                        c_d.rep = c_q.rep + 1'b1;
                        c_d.st  = ST_ARM;
                    end
                end
            end
            ST_DRAIN: begin
                // final window write lands in the bins during this cycle
                c_d.st   = ST_STREAM;
                c_d.sbin = '0;
                c_d.lane = '0;
            end
            ST_STREAM: begin
                out_valid = 1'b1;
                out_last  = final_byte;
                if (out_ready) begin
                    if (final_byte) begin
                        c_d.st = ST_IDLE;
                    end else begin
                        c_d.lane = c_q.lane + 1'b1;
                        if (c_q.lane == LANE_W'(BYTES_PER_BIN - 1)) begin
                            c_d.sbin = c_q.sbin + 1'b1;
                        end
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

endmodule

// File: rtl/coh_window_avg_chk.sv
module coh_window_avg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_last,
    input logic [7:0] out_data
);

    p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)))
        else $error("R8 stream byte changed while stalled");

    p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid)
        else $error("R6 last flag without valid");

    p_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && out_last)) |=> out_valid)
        else $error("R7 stream broke before final byte");

    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid)
        else $error("R11 valid stayed high after final byte");

endmodule

bind coh_window_avg coh_window_avg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .out_data  (out_data)
);

// File: tb/coh_window_avg_test.sv
`timescale 1ns / 1ps
module coh_window_avg_test;

    localparam int MAXB = 16;
    localparam int WIN  = 65;

    typedef struct packed {
        logic        mode;
        logic [3:0]  nb;
        logic [12:0] reps;
        logic [11:0] seed;
        logic        uconst;
        logic [11:0] cval;
        logic [7:0]  ovr_mod;
        logic        midtrig;
        logic        stall;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 4'd2, 13'd3, 12'd5,   1'b0, 12'd0,     8'd0, 1'b0, 1'b0},
        '{1'b1, 4'd3, 13'd2, 12'd9,   1'b0, 12'd0,     8'd0, 1'b1, 1'b0},
        '{1'b0, 4'd1, 13'd4, 12'd200, 1'b0, 12'd0,     8'd7, 1'b0, 1'b1},
        '{1'b1, 4'd2, 13'd2, 12'd77,  1'b0, 12'd0,     8'd5, 1'b0, 1'b1},
        '{1'b0, 4'd4, 13'd1, 12'd3,   1'b0, 12'd0,     8'd0, 1'b1, 1'b0},
        '{1'b1, 4'd1, 13'd1, 12'd0,   1'b1, 12'h000,   8'd0, 1'b0, 1'b0},
        '{1'b0, 4'd1, 13'd2, 12'd0,   1'b1, 12'h000,   8'd1, 1'b0, 1'b1}
    };

    logic        clk;
    logic        rst_n;
    logic        start;
    logic        signed_mode;
    logic [15:0] period_len;
    logic [12:0] rep_total;
    logic        trig;
    logic [11:0] smp;
    logic        smp_ovr;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready;
    logic        out_last;

    int n_chk;
    int n_fail;

    longint exp_bins [MAXB];
    vec_t   cur;

    coh_window_avg uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .signed_mode (signed_mode),
        .period_len  (period_len),
        .rep_total   (rep_total),
        .trig        (trig),
        .smp         (smp),
        .smp_ovr     (smp_ovr),
        .out_data    (out_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_last    (out_last)
    );

    initial begin
        clk = 1'b0;
        forever #2.5 clk = ~clk;
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=expired expected=finished");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int raw_of(input int p, input int i);
        if (cur.uconst) return int'(cur.cval);
        return (int'(cur.seed) * 37 + i * 13 + p * 101) % 4096;
    endfunction

    function automatic longint conv(input int raw, input bit ovr, input bit mode);
        if (mode) return longint'(raw) - 2048;
        if (ovr) return 4095;
        return longint'(raw);
    endfunction

    function automatic string tag_of(input vec_t v);
        if (v.ovr_mod != 0) return "R4";
        if (v.midtrig) return "R5";
        if (v.mode) return "R3";
        return "R2";
    endfunction

    task automatic pulse_start(input bit mode, input int plen, input int reps);
        signed_mode = mode;
        period_len  = 16'(plen);
        rep_total   = 13'(reps);
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // one period of samples; exp_mode is the mode the expectation uses
    task automatic feed_period(input int p, input int plen, input bit exp_mode);
        for (int i = 0; i < plen; i++) begin
            int  r;
            bit  o;
            r       = raw_of(p, i);
            o       = (cur.ovr_mod != 0) && ((i % int'(cur.ovr_mod)) == 0);
            trig    = (i == 0) || (cur.midtrig && i == 70);
            smp     = 12'(r);
            smp_ovr = o;
            exp_bins[i / WIN] += conv(r, o, exp_mode);
            @(negedge clk);
        end
        trig = 1'b0;
        // junk outside an armed period: must be ignored (R5)
        for (int g = 0; g < 4; g++) begin
            smp     = 12'hFFF;
            smp_ovr = 1'b1;
            trig    = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic collect(input int nb, input bit stall, input string tag);
        int k;
        int cyc;
        k   = 0;
        cyc = 0;
        while (k < nb * 4 && cyc < 3000) begin
            bit          rdy;
            logic [31:0] w;
            logic [7:0]  eb;
            rdy       = stall ? ((cyc % 3) != 0) : 1'b1;
            out_ready = rdy;
            #0.5;
            if (out_valid) begin
                w  = exp_bins[k / 4][31:0];
                eb = w[8 * (k % 4) +: 8];
                if (rdy) begin
                    chk(out_data == eb, tag, longint'(out_data), longint'(eb));
                    chk(out_last == (k == nb * 4 - 1), "R6", longint'(out_last), longint'(k == nb * 4 - 1));
                    k++;
                end else begin
                    chk(out_data == eb, "R8", longint'(out_data), longint'(eb));
                end
            end
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        chk(k == nb * 4, "R7", longint'(k), longint'(nb * 4));
        chk(!out_valid, "R11", longint'(out_valid), 0);
        @(negedge clk);
        chk(!out_valid, "R11", longint'(out_valid), 0);
    endtask

    task automatic clear_exp();
        for (int b = 0; b < MAXB; b++) exp_bins[b] = 0;
    endtask

    task automatic run_vec(input vec_t v);
        cur = v;
        clear_exp();
        pulse_start(v.mode, int'(v.nb) * WIN, int'(v.reps));
        repeat (MAXB + 3) @(negedge clk);
        for (int p = 0; p < int'(v.reps); p++) feed_period(p, int'(v.nb) * WIN, v.mode);
        collect(int'(v.nb), v.stall, tag_of(v));
    endtask

    initial begin
        n_chk       = 0;
        n_fail      = 0;
        rst_n       = 1'b0;
        start       = 1'b0;
        signed_mode = 1'b0;
        period_len  = '0;
        rep_total   = '0;
        trig        = 1'b0;
        smp         = '0;
        smp_ovr     = 1'b0;
        out_ready   = 1'b0;
        cur         = '0;
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_last, "R1", longint'({out_valid, out_last}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_last, "R1", longint'({out_valid, out_last}), 0);

        // table of vectors; consecutive runs also show clearing on start (R9)
        for (int v = 0; v < NVEC; v++) run_vec(VECS[v]);

        // R10: start during a run is ignored, configuration unchanged
        cur = VECS[0];
        clear_exp();
        pulse_start(1'b0, 2 * WIN, 2);
        repeat (MAXB + 3) @(negedge clk);
        feed_period(0, 2 * WIN, 1'b0);
        pulse_start(1'b1, WIN, 1);
        repeat (2) @(negedge clk);
        feed_period(1, 2 * WIN, 1'b0);
        collect(2, 1'b0, "R10");

        // R1 and R9: reset in mid-period, then a clean run with fresh bins
        cur = VECS[4];
        pulse_start(1'b0, 2 * WIN, 1);
        repeat (MAXB + 3) @(negedge clk);
        trig = 1'b1;
        smp  = 12'h7FF;
        @(negedge clk);
        trig = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!out_valid && !out_last, "R1", longint'({out_valid, out_last}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R1", longint'(out_valid), 0);
        cur = VECS[0];
        clear_exp();
        pulse_start(1'b0, 2 * WIN, 1);
        repeat (MAXB + 3) @(negedge clk);
        feed_period(0, 2 * WIN, 1'b0);
        collect(2, 1'b1, "R9");

        summary();
        $finish;
    end

endmodule